// File: doc/BRIEF.md
# Multi-match PWM timer with shadow latching

This block is a timer/counter that drives six pulse-width-modulated outputs from seven match registers. The counter advances either on a prescaled copy of the system clock or on synchronized edges of one of two external inputs. Each match register can raise an interrupt flag, send the counter back to zero, or halt it when the count equals the register's value. Match register 0 with reset enabled sets the period. The other six registers place the output edges: one edge per period for single-edge outputs, a rising and a falling edge for dual-edge outputs.

Software programs the block through a single-cycle register write port. When the PWM enable bit is set, new match values go to shadow registers. A shadow value moves to its active register only when that match's latch-enable bit is set and the counter is reset by a match. A duty-cycle change therefore never produces a glitched period. The same two external inputs also serve as capture channels: an enabled edge stores the current count and can raise an interrupt flag.

Top module: `pwm_shadow_timer`

## Requirements
- R1: The control register is at address 0. Bit 0 is counter enable and bit 1 is counter reset: while bit 1 is 1, the counter and prescaler read zero. Bit 3 is PWM enable. When bit 0 is 0, the count holds.
- R2: With count mode 0 (address 1, bits 1:0), the counter advances once every PRE+1 clocks, where PRE is written at address 2. The first advance comes PRE+1 clocks after enable.
- R3: The match values are written at addresses 8 to 14 for matches 0 to 6. In the match-control register (address 3), bit 3n+1 enables reset on match n. On an advance where the count equals match n, a reset-enabled match sends the count to 0 in place of count+1, so match 0 gives a period of MR0+1 advances.
- R4: Match-control bit 3n+2 enables stop on match n. On a hit the count holds its value and the counter-enable bit clears.
- R5: Match-control bit 3n enables the interrupt for match n. The flag register has match 0 to 3 at bits 0 to 3, capture 0 and 1 at bits 4 and 5, and match 4 to 6 at bits 8 to 10. No bit outside mask 0x73F is ever set.
- R6: Writing address 7 clears every flag bit written as 1 and leaves the others. The interrupt request is high exactly when any flag is set.
- R7: Output n is single-edge when it is output 1, or when its select bit n (address 5) is 0. It goes high on the advance where match 0 resets the counter, and low on the advance where the count equals match n. When both fall on the same advance, low wins.
- R8: Outputs 2 to 6 become dual-edge when select bit n at address 5 is set. The output goes high on the advance where the count equals match n-1 and low on the one where it equals match n.
- R9: Output n (pin bit n-1) is driven only when its enable bit n+8 at address 5 is 1 and PWM enable is 1; otherwise it reads 0.
- R10: While PWM enable is 0, a match write takes effect at once. While it is 1, the write goes to a shadow register. The shadow moves to the active register when the counter is reset by any match and latch bit n (address 6) is set; that latch bit then clears.
- R11: Capture channel c uses address 4: bit 3c enables rising-edge capture, bit 3c+1 falling-edge capture, bit 3c+2 the capture interrupt. An enabled edge loads the count into capture register c. An edge that is not enabled changes nothing.
- R12: In count mode 1, 2 or 3 (address 1, bits 1:0), the counter advances on rising, falling or both edges of the input chosen by bit 2 (0 for input 0, 1 for input 1). Each input passes a two-flop synchronizer first, and the input that is not selected has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| cap_i | input | 2 | External capture / count inputs |
| pwm_o | output | 6 | PWM outputs 1 to 6 (bit n-1 is output n) |
| irq_o | output | 1 | Interrupt request |
| flags_o | output | 11 | Sticky interrupt flags |
| count_o | output | CNT_W | Current counter value |
| cap0_o | output | CNT_W | Capture register 0 |
| cap1_o | output | CNT_W | Capture register 1 |

## Verification
The bench builds the block with CNT_W and PRE_W both set to 8. Periods of a few advances and match values above any reachable period can then be combined freely. The bench sweeps every match index through the stop and interrupt path and every single-edge duty value, including the equal-to-period and beyond-period cases. It also sweeps every ordered pair of dual-edge match values within a period. With a short counter, free-running capture windows and all six count-mode and input-select combinations fit in a few hundred cycles each. Expected counts, levels and flag positions come from division and modulo arithmetic on the number of clocks since enable.

// File: rtl/pwm_shadow_timer_pkg.sv
package pwm_shadow_timer_pkg;
    localparam int MATCH_N = 7;
    localparam int OUT_N   = 6;
    localparam int CAP_N   = 2;
    localparam int FLAG_W  = 11;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int MCTL_W  = 3 * MATCH_N;
    localparam int CCTL_W  = 3 * CAP_N;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_MODE   = 4'd1;
    localparam logic [ADDR_W-1:0] A_PRE    = 4'd2;
    localparam logic [ADDR_W-1:0] A_MCTL   = 4'd3;
    localparam logic [ADDR_W-1:0] A_CCTL   = 4'd4;
    localparam logic [ADDR_W-1:0] A_OCTL   = 4'd5;
    localparam logic [ADDR_W-1:0] A_LATCH  = 4'd6;
    localparam logic [ADDR_W-1:0] A_FLAG   = 4'd7;
    localparam logic [ADDR_W-1:0] A_MATCH0 = 4'd8;
    localparam logic [ADDR_W-1:0] A_MLAST  = A_MATCH0 + 4'(MATCH_N - 1);

    localparam logic [FLAG_W-1:0] FLAG_MASK = 11'h73F;

    // count-mode encodings
    typedef enum logic [1:0] {
        CM_TIMER = 2'd0,
        CM_RISE  = 2'd1,
        CM_FALL  = 2'd2,
        CM_BOTH  = 2'd3
    } cnt_mode_e;
endpackage

// File: rtl/pwm_in_sync.sv
module pwm_in_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = din;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise_o[i] =  st_q.s2[i] & ~st_q.prev[i];
        assign fall_o[i] = ~st_q.s2[i] &  st_q.prev[i];
    end
endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
    parameter int CNT_W = 32,
    parameter int N     = 7,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_val,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [CNT_W-1:0]        wr_data,
    input  logic                    wr_latch,
    input  logic [N-1:0]            latch_data,
    input  logic                    pwm_en,
    input  logic                    commit,
    output logic [N-1:0][CNT_W-1:0] act_o
);
    typedef struct packed {
        logic [N-1:0][CNT_W-1:0] shadow;
        logic [N-1:0][CNT_W-1:0] active;
        logic [N-1:0]            latch;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // move armed shadows on a match-driven counter reset
        for (int i = 0; i < N; i++) begin
            if (commit && st_q.latch[i]) begin
                st_d.active[i] = st_q.shadow[i];
                st_d.latch[i]  = 1'b0;
            end
        end
        if (wr_latch) st_d.latch = latch_data;
        if (wr_val) begin
            st_d.shadow[wr_idx] = wr_data;
            if (!pwm_en) st_d.active[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o = st_q.active;
endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen #(
    parameter int N_OUT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             period_start,
    input  logic [N_OUT:1]   hit_i,
    input  logic [N_OUT:2]   dual_sel,
    input  logic [N_OUT:1]   out_en,
    input  logic             pwm_en,
    output logic [N_OUT-1:0] pwm_o
);
    typedef struct packed {
        logic [N_OUT-1:0] lvl;
    } wave_t;

    wave_t            st_d, st_q;
    logic [N_OUT-1:0] set_w;
    logic [N_OUT-1:0] clr_w;

    for (genvar n = 1; n <= N_OUT; n++) begin : g_out
        if (n == 1) begin : g_single
            assign set_w[n-1] = period_start;
        end else begin : g_select
            assign set_w[n-1] = dual_sel[n] ? hit_i[n-1] : period_start;
        end
        assign clr_w[n-1] = hit_i[n];
        assign pwm_o[n-1] = st_q.lvl[n-1] & out_en[n] & pwm_en;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_OUT; i++) begin
            if (clear)         st_d.lvl[i] = 1'b0;
            else if (clr_w[i]) st_d.lvl[i] = 1'b0;
            else if (set_w[i]) st_d.lvl[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer
    import pwm_shadow_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        cap_i,
    output logic [5:0]        pwm_o,
    output logic              irq_o,
    output logic [10:0]       flags_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  cap0_o,
    output logic [CNT_W-1:0]  cap1_o
);
    localparam int IDX_W = $clog2(MATCH_N);

    typedef struct packed {
        logic                        cnt_en;
        logic                        cnt_rst;
        logic                        pwm_en;
        logic [1:0]                  cmode;
        logic                        isel;
        logic [PRE_W-1:0]            pre;
        logic [MCTL_W-1:0]           mctl;
        logic [CCTL_W-1:0]           cctl;
        logic [OUT_N:2]              dual;
        logic [OUT_N:1]              oen;
        logic [PRE_W-1:0]            pc;
        logic [CNT_W-1:0]            tc;
        logic [FLAG_W-1:0]           flags;
        logic [CAP_N-1:0][CNT_W-1:0] cap;
    } tmr_t;

    tmr_t st_d, st_q;

    logic [CAP_N-1:0]              rise_w, fall_w;
    logic [MATCH_N-1:0][CNT_W-1:0] act_w;
    logic [MATCH_N-1:0]            hit_w, rst_hit_w, stop_w, mev_w;
    logic [CAP_N-1:0]              cap_take_w, cev_w;
    logic [FLAG_W-1:0]             flag_ev_w;
    logic                          run_w, tick_w, sel_rise_w, sel_fall_w;
    logic                          mwr_w;
    logic                          cnt_en_w, cnt_rst_w;

    pwm_in_sync #(.N(CAP_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (cap_i),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    assign mwr_w = wr_en && (wr_addr >= A_MATCH0) && (wr_addr <= A_MLAST);

    pwm_match_bank #(.CNT_W(CNT_W), .N(MATCH_N)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_val     (mwr_w),
        .wr_idx     (IDX_W'(wr_addr - A_MATCH0)),
        .wr_data    (wr_data[CNT_W-1:0]),
        .wr_latch   (wr_en && (wr_addr == A_LATCH)),
        .latch_data (wr_data[MATCH_N-1:0]),
        .pwm_en     (st_q.pwm_en),
        .commit     (|rst_hit_w),
        .act_o      (act_w)
    );

    // advance strobe
    assign run_w      = st_q.cnt_en && !st_q.cnt_rst;
    assign sel_rise_w = rise_w[st_q.isel];
    assign sel_fall_w = fall_w[st_q.isel];

    always_comb begin
        unique case (cnt_mode_e'(st_q.cmode))
            CM_TIMER: tick_w = run_w && (st_q.pc == st_q.pre);
            CM_RISE:  tick_w = run_w && sel_rise_w;
            CM_FALL:  tick_w = run_w && sel_fall_w;
            default:  tick_w = run_w && (sel_rise_w || sel_fall_w);
        endcase
    end

    for (genvar i = 0; i < MATCH_N; i++) begin : g_match
        assign hit_w[i]     = tick_w && (st_q.tc == act_w[i]);
        assign mev_w[i]     = hit_w[i] & st_q.mctl[3*i];
        assign rst_hit_w[i] = hit_w[i] & st_q.mctl[3*i+1];
        assign stop_w[i]    = hit_w[i] & st_q.mctl[3*i+2];
    end

    for (genvar c = 0; c < CAP_N; c++) begin : g_cap
        assign cap_take_w[c] = (rise_w[c] & st_q.cctl[3*c]) |
                               (fall_w[c] & st_q.cctl[3*c+1]);
        assign cev_w[c]      = cap_take_w[c] & st_q.cctl[3*c+2];
    end

    assign flag_ev_w = {mev_w[6:4], 2'b00, cev_w, mev_w[3:0]};

    always_comb begin
        st_d = st_q;

        if (st_q.cnt_rst) begin
            st_d.pc = '0;
            st_d.tc = '0;
        end else begin
            if (st_q.cnt_en && (st_q.cmode == CM_TIMER))
                st_d.pc = (st_q.pc == st_q.pre) ? '0 : st_q.pc + PRE_W'(1);
            if (tick_w) begin
                if (|rst_hit_w)    st_d.tc = '0;
                else if (!(|stop_w)) st_d.tc = st_q.tc + CNT_W'(1);
            end
        end
        if (|stop_w) st_d.cnt_en = 1'b0;

        for (int c = 0; c < CAP_N; c++)
            if (cap_take_w[c]) st_d.cap[c] = st_q.tc;

        if (wr_en && (wr_addr == A_FLAG))
            st_d.flags = st_q.flags & ~wr_data[FLAG_W-1:0];
        st_d.flags = (st_d.flags | flag_ev_w) & FLAG_MASK;

        if (wr_en) begin
            unique case (wr_addr)
                A_CTRL: begin
                    st_d.cnt_en  = wr_data[0];
                    st_d.cnt_rst = wr_data[1];
                    st_d.pwm_en  = wr_data[3];
                end
                A_MODE: begin
                    st_d.cmode = wr_data[1:0];
                    st_d.isel  = wr_data[2];
                end
                A_PRE:   st_d.pre  = wr_data[PRE_W-1:0];
                A_MCTL:  st_d.mctl = wr_data[MCTL_W-1:0];
                A_CCTL:  st_d.cctl = wr_data[CCTL_W-1:0];
                A_OCTL: begin
                    st_d.dual = wr_data[OUT_N:2];
                    st_d.oen  = wr_data[OUT_N+8:9];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pwm_wave_gen #(.N_OUT(OUT_N)) u_wave (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (st_q.cnt_rst),
        .period_start (rst_hit_w[0]),
        .hit_i        (hit_w[MATCH_N-1:1]),
        .dual_sel     (st_q.dual),
        .out_en       (st_q.oen),
        .pwm_en       (st_q.pwm_en),
        .pwm_o        (pwm_o)
    );

    assign cnt_en_w  = st_q.cnt_en;
    assign cnt_rst_w = st_q.cnt_rst;
    assign flags_o   = st_q.flags;
    assign irq_o     = |st_q.flags;
    assign count_o   = st_q.tc;
    assign cap0_o    = st_q.cap[0];
    assign cap1_o    = st_q.cap[1];
endmodule

// File: rtl/pwm_shadow_timer_chk.sv
module pwm_shadow_timer_chk
    import pwm_shadow_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [3:0]       wr_addr,
    input logic             cnt_en,
    input logic             cnt_rst,
    input logic [10:0]      flags_o,
    input logic [CNT_W-1:0] count_o
);
    // R5
    flag_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & ~FLAG_MASK) == '0);

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != $past(count_o)) |->
        ((count_o == CNT_W'($past(count_o) + 1'b1)) || (count_o == '0)));

    // R4
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !cnt_rst) |=> $stable(count_o));

    // R1
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |=> (count_o == '0));

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flags_o) & ~flags_o)) |-> $past(wr_en && (wr_addr == A_FLAG)));
endmodule

bind pwm_shadow_timer pwm_shadow_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cnt_en  (cnt_en_w),
    .cnt_rst (cnt_rst_w),
    .flags_o (flags_o),
    .count_o (count_o)
);

// File: tb/pwm_shadow_timer_tb.sv
module pwm_shadow_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [1:0]    cap_i = '0;
    logic [5:0]    pwm_o;
    logic          irq_o;
    logic [10:0]   flags_o;
    logic [CW-1:0] count_o, cap0_o, cap1_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    pwm_shadow_timer #(.CNT_W(CW), .PRE_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cap_i(cap_i), .pwm_o(pwm_o), .irq_o(irq_o),
        .flags_o(flags_o), .count_o(count_o), .cap0_o(cap0_o), .cap1_o(cap1_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic align();
        while (count_o != 0) @(negedge clk);
    endtask

    task automatic init_blk();
        cap_i = '0;
        wr(4'd0, 32'h2);
        for (int i = 0; i < 7; i++) wr(4'(8 + i), 32'd200);
        wr(4'd3, 0); wr(4'd4, 0); wr(4'd5, 0); wr(4'd6, 0);
        wr(4'd2, 0); wr(4'd1, 0);
        idle(4);
        wr(4'd7, 32'h7FF);
    endtask

    task automatic pulse(input int ch);
        cap_i[ch] = 1'b1; idle(4);
        cap_i[ch] = 1'b0; idle(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        logic [CW-1:0] snap;
        int pos;
        idle(2);
        // reset state
        chk("R6 reset irq", irq_o, 0);
        chk("R5 reset flags", flags_o, 0);
        chk("R1 reset count", count_o, 0);
        chk("R9 reset pwm", pwm_o, 0);
        @(negedge clk); rst_n = 1'b1; idle(2);

        // R2 R3: prescale and MR0 period sweep
        for (int pr = 0; pr < 4; pr++) begin
            if (pr == 2) continue;
            for (int pp = 3; pp <= 6; pp += 3) begin
                init_blk();
                wr(4'd8, pp); wr(4'd3, 32'h2); wr(4'd2, pr);
                wr(4'd0, 32'h1);
                for (int j = 0; j <= 40; j++) begin
                    chk($sformatf("R2 R3 pr=%0d mr0=%0d j=%0d", pr, pp, j),
                        count_o, (j / (pr + 1)) % (pp + 1));
                    @(negedge clk);
                end
            end
        end

        // R1: reset hold, enable off
        init_blk();
        wr(4'd8, 50); wr(4'd3, 32'h2); wr(4'd0, 32'h1);
        idle(10);
        wr(4'd0, 32'h3);
        for (int j = 1; j <= 5; j++) begin
            @(negedge clk);
            chk("R1 hold zero", count_o, 0);
        end
        wr(4'd0, 32'h1);
        chk("R1 release j0", count_o, 0);
        idle(3);
        chk("R1 release j3", count_o, 3);
        wr(4'd0, 32'h0);
        snap = count_o;
        idle(6);
        chk("R1 disabled holds", count_o, snap);

        // R4 R5 R6: stop and interrupt on every match index
        for (int n = 0; n < 7; n++) begin
            pos = (n < 4) ? n : n + 4;
            init_blk();
            wr(4'(8 + n), 5);
            wr(4'd3, (32'h1 << (3 * n)) | (32'h1 << (3 * n + 2)));
            wr(4'd0, 32'h1);
            idle(20);
            chk($sformatf("R4 stop m%0d", n), count_o, 5);
            chk($sformatf("R5 flag m%0d", n), flags_o, 32'h1 << pos);
            chk($sformatf("R6 irq m%0d", n), irq_o, 1);
            wr(4'd7, 32'h7FF & ~(32'h1 << pos));
            chk($sformatf("R6 other bits m%0d", n), flags_o, 32'h1 << pos);
            wr(4'd7, 32'h1 << pos);
            chk($sformatf("R6 clear m%0d", n), flags_o, 0);
            chk($sformatf("R6 irq low m%0d", n), irq_o, 0);
        end

        // R7: single-edge duty sweep on output 1, MR0 = 5
        for (int d = 0; d <= 6; d++) begin
            init_blk();
            wr(4'd8, 5); wr(4'd9, d); wr(4'd3, 32'h2);
            wr(4'd5, 32'h1 << 9); wr(4'd0, 32'h9);
            idle(12); align();
            for (int k = 0; k <= 5; k++) begin
                chk($sformatf("R7 d=%0d k=%0d", d, k), pwm_o[0],
                    (d < 5) ? (k <= d) : ((d == 5) ? 0 : 1));
                chk("R9 disabled outputs", pwm_o[5:1], 0);
                @(negedge clk);
            end
        end

        // R8: dual-edge pair sweep on output 2, MR0 = 7
        for (int a = 0; a <= 5; a++) begin
            for (int b = a + 1; b <= 6; b++) begin
                init_blk();
                wr(4'd8, 7); wr(4'd9, a); wr(4'd10, b); wr(4'd3, 32'h2);
                wr(4'd5, (32'h1 << 2) | (32'h1 << 10)); wr(4'd0, 32'h9);
                idle(16); align();
                for (int k = 0; k <= 7; k++) begin
                    chk($sformatf("R8 a=%0d b=%0d k=%0d", a, b, k), pwm_o[1],
                        (k >= a + 1) && (k <= b));
                    chk("R9 out1 not enabled", pwm_o[0], 0);
                    @(negedge clk);
                end
            end
        end
        // R9: PWM enable off gates enabled output
        wr(4'd0, 32'h1);
        for (int k = 0; k < 8; k++) begin
            chk("R9 pwm enable off", pwm_o, 0);
            @(negedge clk);
        end

        // R7: output 2 single-edge when its select bit is 0
        init_blk();
        wr(4'd8, 7); wr(4'd10, 3); wr(4'd3, 32'h2);
        wr(4'd5, 32'h1 << 10); wr(4'd0, 32'h9);
        idle(16); align();
        for (int k = 0; k <= 7; k++) begin
            chk($sformatf("R7 out2 single k=%0d", k), pwm_o[1], k <= 3);
            @(negedge clk);
        end

        // R10: shadow latching (immediate path used while PWM enable is 0)
        init_blk();
        wr(4'd8, 7); wr(4'd9, 2); wr(4'd3, 32'h2);
        wr(4'd5, 32'h1 << 9); wr(4'd0, 32'h9);
        wr(4'd9, 5);
        idle(20); align();
        for (int k = 0; k <= 7; k++) begin
            chk($sformatf("R10 held k=%0d", k), pwm_o[0], k <= 2);
            @(negedge clk);
        end
        wr(4'd6, 32'h1 << 1);
        idle(20); align();
        for (int k = 0; k <= 7; k++) begin
            chk($sformatf("R10 latched k=%0d", k), pwm_o[0], k <= 5);
            @(negedge clk);
        end
        wr(4'd9, 1);
        idle(20); align();
        for (int k = 0; k <= 7; k++) begin
            chk($sformatf("R10 latch bit self-cleared k=%0d", k), pwm_o[0], k <= 5);
            @(negedge clk);
        end

        // R11: capture channels
        init_blk();
        wr(4'd4, 32'h5); wr(4'd0, 32'h1);
        idle(3);
        @(negedge clk); cap_i[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        snap = count_o;
        @(negedge clk);
        chk("R11 cap0 rise value", cap0_o, snap);
        chk("R11 cap0 flag bit4", flags_o, 32'h10);
        cap_i[0] = 1'b0;
        idle(6);
        chk("R11 cap0 fall ignored", cap0_o, snap);
        wr(4'd7, 32'h7FF);
        wr(4'd4, 32'h30);
        cap_i[1] = 1'b1;
        idle(6);
        chk("R11 cap1 rise ignored", cap1_o, 0);
        chk("R11 cap1 no flag", flags_o, 0);
        @(negedge clk); cap_i[1] = 1'b0;
        @(negedge clk); @(negedge clk);
        snap = count_o;
        @(negedge clk);
        chk("R11 cap1 fall value", cap1_o, snap);
        chk("R11 cap1 flag bit5", flags_o, 32'h20);

        // R12: external count modes and input select
        for (int sel = 0; sel < 2; sel++) begin
            for (int m = 1; m <= 3; m++) begin
                init_blk();
                wr(4'd1, m | (sel << 2)); wr(4'd0, 32'h1);
                idle(4);
                for (int p = 0; p < 5; p++) pulse(sel);
                idle(4);
                chk($sformatf("R12 mode=%0d sel=%0d", m, sel), count_o,
                    (m == 3) ? 10 : 5);
                for (int p = 0; p < 3; p++) pulse(1 - sel);
                idle(4);
                chk($sformatf("R12 other input ignored sel=%0d", sel), count_o,
                    (m == 3) ? 10 : 5);
            end
        end

        report();
    end
endmodule